// File: doc/BRIEF.md
# Disk Nibble Read Latch

This block sits on the read path of a floppy controller that delivers a track as a serial stream of flux bits, one per bit cell. Each cell shifts its bit into an 8-bit latch from the low end. Once the top bit of the latch becomes 1, the latch holds a complete nibble, and the block keeps it frozen for a short, decaying hold window. A CPU that polls the latch within that window sees the whole value. When the window closes, the latch shows whatever bits have arrived since completion. A read taken at that point returns a partial nibble with the top bit clear.

Self-synchronising bytes (all ones followed by two zero cells) pull the nibble boundaries back into step with the stream. During long runs of zero cells, the block can turn a zero into a spurious one. This models the unreliable reading of a weak or unmagnetised area. The decision comes from a free-running LFSR compared against a level set on an input port. A read strobe captures the live latch into a registered read-data port.

Top module: `nl_read_latch`

## Requirements
- R1: Reset clears the latch, the read data, the hold counter and the zero-run count, and reloads the LFSR with its seed (16'hACE1).
- R2: Each cycle with `cell_vld` high shifts one effective bit into the collected value at bit 0. While no hold is active, the latch shows that value, so partial nibbles are visible. Cycles without `cell_vld` leave the latch unchanged.
- R3: Suppose a shifted value has bit 7 set while no hold is active. Then the latch shows it, `nib_full` is high, the hold counter is loaded with HOLD_CYC (7 cycles), and collection restarts from zero.
- R4: Every later cell subtracts CELL_CYC (4) from the hold, saturating at zero. While the result is still positive, the latch does not change, but the cell's bit is still collected.
- R5: On the cell where the hold reaches zero, the latch takes all bits collected since completion, that cell's bit included. For example, a complete nibble followed by two one-cells shows 8'h03. Two reads a few cycles apart therefore return the full nibble and then a partial one.
- R6: A stream of sync bytes, each being 8'hFF sent MSB first followed by two zero cells, realigns the latch. After six of them, a following nibble 8'hD5 appears complete and whole.
- R7: Injection applies to a zero cell that follows at least three consecutive raw zero cells. It delivers a one if the LFSR's low 8 bits are below `weak_level`. A raw one cell ends the run. The LFSR advances on every cell: it shifts right and, when the bit shifted out was 1, XORs in 16'hB400. The comparison uses the value held before that cell's step.
- R8: With `weak_level` at 0, no bit is ever injected, so a run of zero cells leaves the latch at zero.
- R9: A cycle with `rd_stb` high copies the latch into `rd_data` on that clock edge. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | One-cycle strobe, one per bit cell |
| cell_bit | input | 1 | Flux bit of the current cell |
| rd_stb | input | 1 | CPU read of the latch |
| weak_level | input | LVL_W (8) | Injection threshold; 0 disables |
| latch_out | output | NIB_W (8) | Live latch value |
| nib_full | output | 1 | Latch bit 7, complete nibble flag |
| rd_data | output | NIB_W (8) | Latch value captured by the last read |

## Verification
The bench builds the block with its default parameters: a 7-cycle hold, 4-cycle cells, a three-cell zero-run threshold and seed 16'hACE1. With these values, one hold covers exactly one ignored cell, which makes both the full-then-partial read pair and sync realignment observable cell by cell. It drives `weak_level` at 0, 255 and 77. Level 0 keeps long zero runs clean. Level 255 makes almost every eligible cell inject, so the three-cell threshold shows at once. Level 77 mixes the two outcomes. The bench predicts every case from its own model of the LFSR sequence.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

  // One Galois step, shifting toward bit 0.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    logic [15:0] n;
    n = {1'b0, s[15:1]};
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

  // Hold decay: subtract one cell worth of cycles, floor at zero.
  function automatic int hold_decay(input int h, input int step);
    return (h > step) ? h - step : 0;
  endfunction
endpackage

// File: rtl/nl_weak_gen.sv
module nl_weak_gen #(
  parameter int          ZRUN_MIN  = 3,
  parameter int          LVL_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         ZW        = $clog2(ZRUN_MIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_vld,
  input  logic             cell_bit,
  input  logic [LVL_W-1:0] weak_level,
  output logic             eff_bit,
  output logic             inj_pulse,
  output logic [ZW-1:0]    zrun_q
);
  import nl_pkg::*;

  logic [15:0] lfsr_q;
  logic        run_long;
  logic        below;

  assign run_long  = (zrun_q == ZW'(ZRUN_MIN));
  assign below     = (lfsr_q[LVL_W-1:0] < weak_level);
  assign inj_pulse = cell_vld && !cell_bit && run_long && below;
  assign eff_bit   = cell_bit | inj_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_SEED;
      zrun_q <= '0;
    end else if (cell_vld) begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (cell_bit)
        zrun_q <= '0;
      else if (!run_long)
        zrun_q <= zrun_q + 1'b1;
    end
  end
endmodule

// File: rtl/nl_shift_hold.sv
module nl_shift_hold #(
  parameter int  NIB_W    = 8,
  parameter int  HOLD_CYC = 7,
  parameter int  CELL_CYC = 4,
  localparam int HW       = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_vld,
  input  logic             eff_bit,
  output logic [NIB_W-1:0] latch_q,
  output logic [HW-1:0]    hold_q,
  output logic             cmpl_evt
);
  import nl_pkg::*;

  logic [NIB_W-1:0] acc_q;
  logic [NIB_W-1:0] acc_n;
  logic [HW-1:0]    hold_dec;
  logic             keep;

  assign acc_n    = {acc_q[NIB_W-2:0], eff_bit};
  assign hold_dec = HW'(hold_decay(int'(hold_q), CELL_CYC));
  assign keep     = (hold_q != '0) && (hold_dec != '0);
  assign cmpl_evt = cell_vld && !keep && acc_n[NIB_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      latch_q <= '0;
      hold_q  <= '0;
    end else if (cell_vld) begin
      if (keep) begin
        hold_q <= hold_dec;
        acc_q  <= acc_n;
      end else begin
        latch_q <= acc_n;
        if (acc_n[NIB_W-1]) begin
          hold_q <= HW'(HOLD_CYC);
          acc_q  <= '0;
        end else begin
          hold_q <= '0;
          acc_q  <= acc_n;
        end
      end
    end
  end
endmodule

// File: rtl/nl_read_port.sv
module nl_read_port #(
  parameter int NIB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [NIB_W-1:0] latch_q,
  output logic [NIB_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= latch_q;
  end
endmodule

// File: rtl/nl_read_latch.sv
module nl_read_latch #(
  parameter int          NIB_W     = 8,
  parameter int          HOLD_CYC  = 7,
  parameter int          CELL_CYC  = 4,
  parameter int          ZRUN_MIN  = 3,
  parameter int          LVL_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_vld,
  input  logic             cell_bit,
  input  logic             rd_stb,
  input  logic [LVL_W-1:0] weak_level,
  output logic [NIB_W-1:0] latch_out,
  output logic             nib_full,
  output logic [NIB_W-1:0] rd_data
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int ZW = $clog2(ZRUN_MIN + 1);

  // Named internal events, observed by the bound checker.
  logic          eff_bit;
  logic          inj_pulse;
  logic [ZW-1:0] zrun_q;
  logic [HW-1:0] hold_q;
  logic          cmpl_evt;

  nl_weak_gen #(
    .ZRUN_MIN (ZRUN_MIN),
    .LVL_W    (LVL_W),
    .LFSR_SEED(LFSR_SEED)
  ) u_weak (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_vld  (cell_vld),
    .cell_bit  (cell_bit),
    .weak_level(weak_level),
    .eff_bit   (eff_bit),
    .inj_pulse (inj_pulse),
    .zrun_q    (zrun_q)
  );

  nl_shift_hold #(
    .NIB_W   (NIB_W),
    .HOLD_CYC(HOLD_CYC),
    .CELL_CYC(CELL_CYC)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .cell_vld(cell_vld),
    .eff_bit (eff_bit),
    .latch_q (latch_out),
    .hold_q  (hold_q),
    .cmpl_evt(cmpl_evt)
  );

  nl_read_port #(.NIB_W(NIB_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .latch_q(latch_out),
    .rd_data(rd_data)
  );

  assign nib_full = latch_out[NIB_W-1];
endmodule

// File: rtl/nl_read_latch_chk.sv
module nl_read_latch_chk #(
  parameter int NIB_W    = 8,
  parameter int HOLD_CYC = 7,
  parameter int CELL_CYC = 4,
  parameter int ZRUN_MIN = 3,
  parameter int LVL_W    = 8,
  parameter int HW       = 3,
  parameter int ZW       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cell_vld,
  input logic             cell_bit,
  input logic             rd_stb,
  input logic [LVL_W-1:0] weak_level,
  input logic [NIB_W-1:0] latch_out,
  input logic [NIB_W-1:0] rd_data,
  input logic [HW-1:0]    hold_q,
  input logic [ZW-1:0]    zrun_q,
  input logic             inj_pulse,
  input logic             cmpl_evt
);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_vld |=> $stable(latch_out));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_evt |=> (int'(hold_q) == HOLD_CYC) && latch_out[NIB_W-1]);

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && int'(hold_q) > CELL_CYC) |=> $stable(latch_out));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hold_q) <= HOLD_CYC);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> (int'(zrun_q) == ZRUN_MIN) && !cell_bit);

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (weak_level == '0) |-> !inj_pulse);

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_data == $past(latch_out));

  p_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind nl_read_latch nl_read_latch_chk #(
  .NIB_W   (NIB_W),
  .HOLD_CYC(HOLD_CYC),
  .CELL_CYC(CELL_CYC),
  .ZRUN_MIN(ZRUN_MIN),
  .LVL_W   (LVL_W),
  .HW      (HW),
  .ZW      (ZW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cell_vld  (cell_vld),
  .cell_bit  (cell_bit),
  .rd_stb    (rd_stb),
  .weak_level(weak_level),
  .latch_out (latch_out),
  .rd_data   (rd_data),
  .hold_q    (hold_q),
  .zrun_q    (zrun_q),
  .inj_pulse (inj_pulse),
  .cmpl_evt  (cmpl_evt)
);

// File: tb/test_nl_read_latch.sv
module test_nl_read_latch;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cell_vld = 1'b0;
  logic       cell_bit = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] weak_level = 8'd0;
  logic [7:0] latch_out;
  logic       nib_full;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  typedef struct { int exp; string req; } item_t;
  item_t sb_q[$];

  // Reference state, kept in plain integers.
  int m_acc, m_hold, m_latch, m_zrun;
  int m_lfsr;

  always #(CLK_P/2) clk = ~clk;

  nl_read_latch i_nl_read_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_vld  (cell_vld),
    .cell_bit  (cell_bit),
    .rd_stb    (rd_stb),
    .weak_level(weak_level),
    .latch_out (latch_out),
    .nib_full  (nib_full),
    .rd_data   (rd_data)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_hold = 0; m_latch = 0; m_zrun = 0; m_lfsr = 'hACE1;
  endtask

  task automatic model_cell(input int b);
    int inj, e, nacc;
    inj = (weak_level != 0 && m_zrun >= 3 && b == 0 && (m_lfsr % 256) < weak_level) ? 1 : 0;
    if (m_lfsr % 2 == 1) m_lfsr = (m_lfsr / 2) ^ 'hB400;
    else                 m_lfsr = m_lfsr / 2;
    m_zrun = b ? 0 : m_zrun + 1;
    e = b | inj;
    nacc = (m_acc * 2 + e) % 256;
    if (m_hold > 4) begin
      m_hold = m_hold - 4;
      m_acc = nacc;
    end else begin
      m_latch = nacc;
      if (nacc >= 128) begin m_hold = 7; m_acc = 0; end
      else begin m_hold = 0; m_acc = nacc; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Driver: one bit cell of four clock cycles; expected latch goes to the queue.
  task automatic send_cell(input int b, input string req);
    item_t it;
    @(negedge clk);
    cell_vld = 1'b1;
    cell_bit = b[0];
    @(negedge clk);
    cell_vld = 1'b0;
    cell_bit = 1'b0;
    model_cell(b);
    it.exp = m_latch;
    it.req = req;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input string req);
    for (int i = 7; i >= 0; i--) send_cell(int'(v[i]), req);
  endtask

  task automatic do_read(input int exp, input string req);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(int'(rd_data), exp, req);
  endtask

  // Monitor: compares each queued expectation with the live latch.
  initial begin
    item_t it;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      chk(int'(latch_out), it.exp, it.req);
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    model_reset();
    do_reset();
    // R1: reset state
    chk(int'(latch_out), 0, "R1 latch");
    chk(int'(rd_data), 0, "R1 rd_data");
    chk(int'(nib_full), 0, "R1 nib_full");

    // R2: partial nibble builds from the low end
    send_cell(1, "R2"); send_cell(0, "R2"); send_cell(1, "R2");
    chk(int'(latch_out), 'h05, "R2 partial");
    repeat (3) @(negedge clk);
    chk(int'(latch_out), 'h05, "R2 idle cycles");

    // R3: completion at bit 7
    send_cell(1, "R3"); send_cell(0, "R3"); send_cell(1, "R3");
    send_cell(0, "R3"); send_cell(1, "R3");
    chk(int'(latch_out), 'hB5, "R3 complete");
    chk(int'(nib_full), 1, "R3 nib_full");

    // R4: first following cell is held
    send_cell(1, "R4");
    chk(int'(latch_out), 'hB5, "R4 held");
    do_read('hB5, "R9 full read");
    // R5: hold expires, collected bits appear
    send_cell(1, "R5");
    chk(int'(latch_out), 'h03, "R5 partial after hold");
    do_read('h03, "R5 second read partial");
    send_cell(0, "R9");
    chk(int'(rd_data), 'h03, "R9 rd_data steady");

    // R6: garbage, six sync bytes, then a data nibble
    send_cell(0, "R6"); send_cell(1, "R6");
    for (int k = 0; k < 6; k++) begin
      send_byte(8'hFF, "R6");
      send_cell(0, "R6"); send_cell(0, "R6");
    end
    send_byte(8'hD5, "R6");
    chk(int'(latch_out), 'hD5, "R6 realigned nibble");

    // R8: long zero run with injection off
    weak_level = 8'd0;
    for (int k = 0; k < 12; k++) send_cell(0, "R8");
    chk(int'(latch_out), 0, "R8 zeros stay zero");

    // R7: threshold of three raw zeros, then injection
    send_cell(1, "R7");
    weak_level = 8'd255;
    send_cell(0, "R7"); send_cell(0, "R7"); send_cell(0, "R7");
    chk(int'(latch_out), 'h08, "R7 no injection before run");
    for (int k = 0; k < 20; k++) send_cell(0, "R7");
    weak_level = 8'd77;
    for (int k = 0; k < 40; k++) send_cell(0, "R7");
    send_byte(8'hA9, "R7");

    // R1: reset in the middle of a stream
    weak_level = 8'd0;
    send_byte(8'hFF, "R3");
    do_reset();
    chk(int'(latch_out), 0, "R1 mid-stream latch");
    chk(int'(rd_data), 0, "R1 mid-stream rd_data");
    send_cell(1, "R1 lfsr reseed");

    repeat (4) @(negedge clk);
    report();
  end
endmodule